// File: doc/BRIEF.md
# Dual-Channel ADC Offset Calibration Controller

This block sits behind a two-channel 14-bit serial converter and turns its raw conversion codes into offset-corrected results. It watches the converter's active-low chip select and its serial clock, both sampled in the system clock domain, to frame each conversion. A frame opens on a chip-select falling edge and completes on the 19th serial-clock rising edge. When the frame opens, the block decides whether the frame is a normal conversion or an offset calibration. The decision comes from the calibration pin level at that edge, or from a calibration request written earlier through a one-cycle register-write strobe.

In a calibration frame the converter inputs are shorted, so the raw code of each channel is the offset of that channel. The block clamps it to a correctable window and stores it. Every later normal conversion has the stored offset of its channel subtracted, and the difference saturates to the 14-bit two's-complement range. A request raised while a frame is running marks that frame as corrupted. A chip-select rise before the frame completes aborts the frame. A change of the gain setting raises a sticky flag saying that the stored offsets no longer match the gain.

Top module: `adcOffsetCal`

## Requirements
- R1: Frame type is decided only at the chip-select falling edge. The frame is a calibration frame when `calPin` is 1 at that edge or a calibration request is pending; otherwise it is a normal frame. Changes of `calPin` while chip select is high have no effect on the frame type.
- R2: A frame completes on the 19th `sclk` rising edge after the chip-select fall. On the next clock, `resValid` pulses for one cycle if the frame was normal, or `calDone` pulses for one cycle if it was a calibration frame. At most one of `resValid`, `calDone` and `abortPulse` is high in any cycle.
- R3: While `calPin` stays at 1 across several frames, each of those frames is a calibration frame.
- R4: A rising edge of `calPin` while a frame is running (chip select low, fewer than 19 clocks counted) sets `resCorrupt` = 1 with that frame's completion pulse. A corrupted calibration frame leaves the stored offsets and `recalNeeded` unchanged.
- R5: A one-cycle pulse on `calBitWr` schedules a calibration for the next chip-select falling edge. If the pulse arrives while a frame is running, that frame completes with `resCorrupt` = 1. The request is consumed by the frame it starts, and the frame after that is normal unless requested again.
- R6: An uncorrupted calibration frame stores the raw code of each channel, clamped to the range −500 to +500, as that channel's offset. `rdData` shows the offset of channel A when `rdSel` = 0 and of channel B when `rdSel` = 1, as 14-bit two's complement.
- R7: A normal frame sets `resA` = rawA − offsetA and `resB` = rawB − offsetB. All values are 14-bit two's complement, and each result saturates to −8192 or +8191 instead of wrapping.
- R8: Any change of `gainSel` sets `recalNeeded` on the next clock. The flag stays set, with the old offsets still applied, until an uncorrupted calibration frame completes.
- R9: A chip-select rise before the 19th clock aborts the frame. `abortPulse` pulses for one cycle, and results, offsets and `resCorrupt` stay unchanged.
- R10: After reset, both stored offsets are 0, results are 0, all pulses are 0 and `recalNeeded` is 0.
- R11: Serial clocks after the 19th clock of a frame are ignored until chip select rises. They produce no further pulses and no change of the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Converter chip select, active low |
| sclk | input | 1 | Converter serial clock, sampled by clk |
| calPin | input | 1 | Calibration request level |
| calBitWr | input | 1 | One-cycle strobe: write 1 to the calibration control bit |
| gainSel | input | GAIN_W (3) | Current amplifier gain setting |
| rawA | input | CODE_W (14) | Raw code of channel A, valid at the 19th clock |
| rawB | input | CODE_W (14) | Raw code of channel B, valid at the 19th clock |
| rdSel | input | 1 | Offset read select: 0 = A, 1 = B |
| rdData | output | CODE_W (14) | Selected stored offset |
| resA | output | CODE_W (14) | Corrected result, channel A |
| resB | output | CODE_W (14) | Corrected result, channel B |
| resValid | output | 1 | Normal frame completed |
| resCorrupt | output | 1 | Last completed frame was corrupted |
| calDone | output | 1 | Calibration frame completed |
| abortPulse | output | 1 | Frame aborted by an early chip-select rise |
| recalNeeded | output | 1 | Gain changed since the last good calibration |

## Verification
A wrong frame counter shows up as a completion pulse that is one clock early or late relative to the 19th serial clock, or as a pulse caused by clocks beyond the 19th. Either error is visible within the same frame. A wrong frame-type decision, or a pending request that is never cleared, shows up as `calDone` in place of `resValid`, and the offsets read through `rdData` move in the same frame. Bad offset storage stays hidden until the next normal frame, where every result of that channel carries the error, so the bench checks `rdData` right after each calibration rather than waiting for that frame.

// File: rtl/adcCalPkg.sv
package adcCalPkg;
  // strobes from the frame sequencer to the correction datapath
  typedef struct packed {
    logic finish;    // frame reached its last serial clock
    logic frameCal;  // current frame is a calibration frame
    logic frameBad;  // current frame has been corrupted
    logic calGood;   // calibration frame finished clean
    logic abort;     // frame ended early
  } calStrobe_t;
endpackage

// File: rtl/calCtrl.sv
module calCtrl
  import adcCalPkg::*;
#(
  parameter int FRAME_CLKS = 19
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       calPin,
  input  logic       calBitWr,
  output calStrobe_t strb
);
  localparam int CNT_W = $clog2(FRAME_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_CLKS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} frameState_t;

  frameState_t state;
  logic [CNT_W-1:0] clkCnt;
  logic csQ, sclkQ, calPinQ;
  logic isCal, isBad, calPending;

  logic csFall, csRise, sclkRise, pinRise, badNow, lastClk;

  assign csFall   = csQ & ~csN;
  assign csRise   = ~csQ & csN;
  assign sclkRise = ~sclkQ & sclk;
  assign pinRise  = ~calPinQ & calPin;
  assign badNow   = isBad | pinRise | calBitWr;
  assign lastClk  = (state == ST_RUN) && !csRise && sclkRise && (clkCnt == LAST_CNT);

  always_comb begin
    strb.finish   = lastClk;
    strb.frameCal = isCal;
    strb.frameBad = badNow;
    strb.calGood  = lastClk && isCal && !badNow;
    strb.abort    = (state == ST_RUN) && csRise;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ        <= 1'b1;
      sclkQ      <= 1'b0;
      calPinQ    <= 1'b0;
      state      <= ST_IDLE;
      clkCnt     <= '0;
      isCal      <= 1'b0;
      isBad      <= 1'b0;
      calPending <= 1'b0;
    end else begin
      csQ     <= csN;
      sclkQ   <= sclk;
      calPinQ <= calPin;
      case (state)
        ST_IDLE: begin
          if (csFall) begin
            state      <= ST_RUN;
            clkCnt     <= '0;
            isCal      <= calPin | calPending;
            isBad      <= 1'b0;
            calPending <= calBitWr;
          end else if (calBitWr) begin
            calPending <= 1'b1;
          end
        end
        ST_RUN: begin
          isBad <= badNow;
          if (calBitWr) calPending <= 1'b1;
          if (csRise) begin
            state <= ST_IDLE;
          end else if (sclkRise) begin
            if (clkCnt == LAST_CNT) state <= ST_HOLD;
            else clkCnt <= clkCnt + 1'b1;
          end
        end
        default: begin
          if (calBitWr) calPending <= 1'b1;
          if (csRise) state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/calDatapath.sv
module calDatapath
  import adcCalPkg::*;
#(
  parameter int CODE_W    = 14,
  parameter int OFF_LIMIT = 500,
  parameter int GAIN_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strb,
  input  logic [GAIN_W-1:0] gainSel,
  input  logic [CODE_W-1:0] rawA,
  input  logic [CODE_W-1:0] rawB,
  input  logic              rdSel,
  output logic [CODE_W-1:0] rdData,
  output logic [CODE_W-1:0] resA,
  output logic [CODE_W-1:0] resB,
  output logic              resValid,
  output logic              resCorrupt,
  output logic              calDone,
  output logic              abortPulse,
  output logic              recalNeeded
);
  localparam int NCH = 2;
  localparam logic signed [CODE_W-1:0] OFF_HI   = CODE_W'(OFF_LIMIT);
  localparam logic signed [CODE_W-1:0] OFF_LO   = CODE_W'(-OFF_LIMIT);
  localparam logic signed [CODE_W:0]   CODE_MAX = {2'b00, {(CODE_W-1){1'b1}}};
  localparam logic signed [CODE_W:0]   CODE_MIN = {2'b11, {(CODE_W-1){1'b0}}};

  logic signed [CODE_W-1:0] rawCh [NCH];
  logic signed [CODE_W-1:0] offCh [NCH];
  logic signed [CODE_W-1:0] resCh [NCH];
  logic [GAIN_W-1:0] gainQ;

  assign rawCh[0] = $signed(rawA);
  assign rawCh[1] = $signed(rawB);

  function automatic logic signed [CODE_W-1:0] clampOffset(input logic signed [CODE_W-1:0] v);
    if (v > OFF_HI) return OFF_HI;
    if (v < OFF_LO) return OFF_LO;
    return v;
  endfunction

  function automatic logic signed [CODE_W-1:0] subSat(input logic signed [CODE_W-1:0] a,
                                                      input logic signed [CODE_W-1:0] b);
    logic signed [CODE_W:0] diff;
    diff = {a[CODE_W-1], a} - {b[CODE_W-1], b};
    if (diff > CODE_MAX) return CODE_MAX[CODE_W-1:0];
    if (diff < CODE_MIN) return CODE_MIN[CODE_W-1:0];
    return diff[CODE_W-1:0];
  endfunction

  for (genvar ch = 0; ch < NCH; ch++) begin : gChan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        offCh[ch] <= '0;
        resCh[ch] <= '0;
      end else if (strb.finish) begin
        if (strb.calGood) offCh[ch] <= clampOffset(rawCh[ch]);
        else if (!strb.frameCal) resCh[ch] <= subSat(rawCh[ch], offCh[ch]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid    <= 1'b0;
      calDone     <= 1'b0;
      abortPulse  <= 1'b0;
      resCorrupt  <= 1'b0;
      recalNeeded <= 1'b0;
      gainQ       <= '0;
    end else begin
      resValid   <= strb.finish && !strb.frameCal;
      calDone    <= strb.finish && strb.frameCal;
      abortPulse <= strb.abort;
      if (strb.finish) resCorrupt <= strb.frameBad;
      gainQ <= gainSel;
      if (gainSel != gainQ) recalNeeded <= 1'b1;
      else if (strb.calGood) recalNeeded <= 1'b0;
    end
  end

  assign resA   = resCh[0];
  assign resB   = resCh[1];
  assign rdData = rdSel ? offCh[1] : offCh[0];
endmodule

// File: rtl/adcOffsetCal.sv
module adcOffsetCal
  import adcCalPkg::*;
#(
  parameter int CODE_W     = 14,
  parameter int FRAME_CLKS = 19,
  parameter int OFF_LIMIT  = 500,
  parameter int GAIN_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              calPin,
  input  logic              calBitWr,
  input  logic [GAIN_W-1:0] gainSel,
  input  logic [CODE_W-1:0] rawA,
  input  logic [CODE_W-1:0] rawB,
  input  logic              rdSel,
  output logic [CODE_W-1:0] rdData,
  output logic [CODE_W-1:0] resA,
  output logic [CODE_W-1:0] resB,
  output logic              resValid,
  output logic              resCorrupt,
  output logic              calDone,
  output logic              abortPulse,
  output logic              recalNeeded
);
  calStrobe_t strb;

  calCtrl #(.FRAME_CLKS(FRAME_CLKS)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
    .calPin(calPin), .calBitWr(calBitWr), .strb(strb)
  );

  calDatapath #(.CODE_W(CODE_W), .OFF_LIMIT(OFF_LIMIT), .GAIN_W(GAIN_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .gainSel(gainSel),
    .rawA(rawA), .rawB(rawB), .rdSel(rdSel), .rdData(rdData),
    .resA(resA), .resB(resB), .resValid(resValid), .resCorrupt(resCorrupt),
    .calDone(calDone), .abortPulse(abortPulse), .recalNeeded(recalNeeded)
  );
endmodule

// File: rtl/adcOffsetCalChk.sv
module adcOffsetCalChk #(
  parameter int CODE_W    = 14,
  parameter int OFF_LIMIT = 500,
  parameter int GAIN_W    = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [GAIN_W-1:0] gainSel,
  input logic              rdSel,
  input logic [CODE_W-1:0] rdData,
  input logic [CODE_W-1:0] resA,
  input logic [CODE_W-1:0] resB,
  input logic              resValid,
  input logic              resCorrupt,
  input logic              calDone,
  input logic              abortPulse,
  input logic              recalNeeded
);
  localparam logic signed [CODE_W-1:0] OFF_HI = CODE_W'(OFF_LIMIT);
  localparam logic signed [CODE_W-1:0] OFF_LO = CODE_W'(-OFF_LIMIT);

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({resValid, calDone, abortPulse}) <= 1);  // R2

  AST_OFFSET_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(rdData) <= OFF_HI) && ($signed(rdData) >= OFF_LO));  // R6

  AST_OFFSET_ONLY_CLEAN_CAL: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(rdSel) && !$stable(rdData)) |-> (calDone && !resCorrupt));  // R4

  AST_ABORT_KEEPS_RESULTS: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> ($stable(resA) && $stable(resB) && $stable(resCorrupt)));  // R9

  AST_GAIN_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (gainSel != $past(gainSel)) |=> recalNeeded);  // R8
endmodule

bind adcOffsetCal adcOffsetCalChk #(.CODE_W(CODE_W), .OFF_LIMIT(OFF_LIMIT), .GAIN_W(GAIN_W)) uChk (
  .clk(clk), .rstN(rstN), .gainSel(gainSel), .rdSel(rdSel), .rdData(rdData),
  .resA(resA), .resB(resB), .resValid(resValid), .resCorrupt(resCorrupt),
  .calDone(calDone), .abortPulse(abortPulse), .recalNeeded(recalNeeded)
);

// File: tb/adcOffsetCal_test.sv
module adcOffsetCal_test;
  localparam int CLK_PERIOD = 10;
  localparam int MODE_PLAIN = 0, MODE_PINRISE = 1, MODE_WRMID = 2, MODE_ABORT = 3, MODE_EXTRA = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, calPin = 1'b0, calBitWr = 1'b0, rdSel = 1'b0;
  logic [2:0] gainSel = '0;
  logic [13:0] rawA = '0, rawB = '0;
  logic [13:0] rdData, resA, resB;
  logic resValid, resCorrupt, calDone, abortPulse, recalNeeded;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // bench model
  int offA = 0, offB = 0, lastA = 0, lastB = 0;
  bit pend = 0, recal = 0, lastBad = 0;

  adcOffsetCal uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .calPin(calPin), .calBitWr(calBitWr),
    .gainSel(gainSel), .rawA(rawA), .rawB(rawB), .rdSel(rdSel), .rdData(rdData),
    .resA(resA), .resB(resB), .resValid(resValid), .resCorrupt(resCorrupt),
    .calDone(calDone), .abortPulse(abortPulse), .recalNeeded(recalNeeded)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int satOff(input int v);
    if (v > 500) return 500;
    if (v < -500) return -500;
    return v;
  endfunction

  function automatic int satCode(input int v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  function automatic int s14(input logic [13:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkOffsets(input string tag);
    rdSel = 1'b0; #1;
    chk({tag, " offset A"}, s14(rdData), offA);
    rdSel = 1'b1; #1;
    chk({tag, " offset B"}, s14(rdData), offB);
    rdSel = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic setGain(input logic [2:0] g);
    @(negedge clk);
    if (g != gainSel) recal = 1;
    gainSel = g;
    @(negedge clk);
    chk("R8 recalNeeded after gain change", int'(recalNeeded), int'(recal));
  endtask

  // one frame: pin level at the falling edge, raw codes, and a disturbance mode
  task automatic runFrame(input logic pin, input int a, input int b, input int mode);
    bit isCal, bad;
    @(negedge clk);
    calPin = pin;
    rawA = a[13:0];
    rawB = b[13:0];
    @(negedge clk);
    @(negedge clk);
    csN = 1'b0;
    isCal = pin | pend;
    pend = 0;
    bad = (mode == MODE_PINRISE) || (mode == MODE_WRMID);
    if (mode == MODE_WRMID) pend = 1;
    @(negedge clk);
    for (int i = 1; i <= 19; i++) begin
      @(negedge clk);
      if (mode == MODE_ABORT && i == 10) begin
        csN = 1'b1;
        @(negedge clk);
        chk("R9 abortPulse", int'(abortPulse), 1);
        chk("R9 resA kept", s14(resA), lastA);
        chk("R9 resCorrupt kept", int'(resCorrupt), int'(lastBad));
        checkOffsets("R9");
        return;
      end
      sclk = 1'b1;
      if (mode == MODE_PINRISE && i == 5) calPin = 1'b1;
      if (mode == MODE_WRMID && i == 5) calBitWr = 1'b1;
      @(negedge clk);
      sclk = 1'b0;
      calBitWr = 1'b0;
      if (i < 19) begin
        if (resValid || calDone) chk("R2 early completion pulse", 1, 0);
      end
    end
    // outputs from the 19th clock are visible now
    lastBad = bad;
    if (isCal) begin
      chk("R2 calDone pulse", int'(calDone), 1);
      chk("R2 no resValid on calibration", int'(resValid), 0);
      chk("R4 corrupt flag (cal)", int'(resCorrupt), int'(bad));
      if (!bad) begin
        offA = satOff(a);
        offB = satOff(b);
        if (gainSel == uut.gainSel) recal = 0;
      end
      checkOffsets("R6");
    end else begin
      lastA = satCode(a - offA);
      lastB = satCode(b - offB);
      chk("R2 resValid pulse", int'(resValid), 1);
      chk("R7 resA", s14(resA), lastA);
      chk("R7 resB", s14(resB), lastB);
      chk("R4 corrupt flag (normal)", int'(resCorrupt), int'(bad));
    end
    chk("R8 recalNeeded", int'(recalNeeded), int'(recal));
    if (mode == MODE_EXTRA) begin
      rawA = 14'(a + 1234);
      rawB = 14'(b - 77);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); sclk = 1'b1;
        @(negedge clk); sclk = 1'b0;
        if (resValid || calDone) chk("R11 pulse from extra clock", 1, 0);
      end
      chk("R11 resA after extra clocks", s14(resA), lastA);
      checkOffsets("R11");
    end
    @(negedge clk);
    csN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 resValid", int'(resValid), 0);
    chk("R10 calDone", int'(calDone), 0);
    chk("R10 abortPulse", int'(abortPulse), 0);
    chk("R10 recalNeeded", int'(recalNeeded), 0);
    chk("R10 resA", s14(resA), 0);
    checkOffsets("R10");

    // normal frame with zero offsets
    runFrame(1'b0, 1000, -2000, MODE_PLAIN);
    // R1: pin pulsed while chip select high does not make a calibration
    @(negedge clk); calPin = 1'b1; @(negedge clk); calPin = 1'b0;
    runFrame(1'b0, 5, 6, MODE_PLAIN);
    // R6 saturation of stored offsets
    runFrame(1'b1, 700, -8192, MODE_PLAIN);
    // R7 result saturation at both code limits
    runFrame(1'b0, -8192, 8191, MODE_PLAIN);
    runFrame(1'b1, 120, -45, MODE_PLAIN);
    // R3 pin held across three frames
    runFrame(1'b1, -500, 499, MODE_PLAIN);
    runFrame(1'b1, 33, -33, MODE_PLAIN);
    runFrame(1'b1, -501, 501, MODE_PLAIN);
    runFrame(1'b0, 100, -100, MODE_PLAIN);
    // R5 write in idle schedules next frame
    @(negedge clk); calBitWr = 1'b1; pend = 1; @(negedge clk); calBitWr = 1'b0;
    runFrame(1'b0, 20, 30, MODE_PLAIN);
    runFrame(1'b0, 200, 300, MODE_PLAIN);
    // R5 write mid-frame: current corrupt, next is calibration
    runFrame(1'b0, 400, 400, MODE_WRMID);
    runFrame(1'b0, -7, 9, MODE_PLAIN);
    // R4 pin rise mid-frame
    runFrame(1'b0, 50, 60, MODE_PINRISE);
    // R8 gain change, old offsets still applied, cleared by calibration
    setGain(3'd2);
    runFrame(1'b0, 1, 2, MODE_PLAIN);
    runFrame(1'b1, 10, -10, MODE_PLAIN);
    // R9 abort, R11 extra clocks
    runFrame(1'b0, 3000, 3000, MODE_ABORT);
    runFrame(1'b0, 3000, -3000, MODE_EXTRA);

    // constrained random frames
    for (int n = 0; n < 60; n++) begin
      int mode;
      logic pin;
      int a, b;
      mode = int'($urandom % 5);
      pin = (($urandom % 4) == 0);
      if (mode == MODE_PINRISE) pin = 1'b0;
      if (pin && ($urandom % 2 == 0)) begin
        a = int'($urandom % 1201) - 600;
        b = int'($urandom % 1201) - 600;
      end else begin
        a = s14(14'($urandom));
        b = s14(14'($urandom));
      end
      if ($urandom % 10 == 0) setGain(3'($urandom));
      runFrame(pin, a, b, mode);
    end
    finish_run();
  end
endmodule